// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers twenty-eight interrupt sources and turns them into two CPU request lines. The sources are one fast external pin, eight general external pins and nineteen internal peripheral lines. The fast pin feeds a separate fast-request output and never enters the normal request path. Every source has a fixed number and a three-bit priority level, and level 0 turns the source off. The block keeps one pending bit for each source. A small stack of service levels lets a higher-level request interrupt a handler that is already running.

Software sets the levels through a small register bus and clears pending bits by writing ones to them. It acknowledges a request by reading the number register, which returns the winning source number. That read also raises the current service level to the level of the winner and clears the winner's pending bit. Writing the end-of-service register brings back the level that was in force before the acknowledge. External pins are active low and pass through a synchronizer. A pin must be seen low on two consecutive clock edges after being high before its request is taken.

Top module: `lic_top`

## Requirements
- R1: After reset, every level field reads 0, the pending register reads 0, `irq` and `fiq` are low, and the status register (address 7) reads 0.
- R2: General pin k (`ext_req_n[k]`) sets pending bit k+1 when it is sampled low on two or more consecutive edges after being high. A low pulse that covers only one edge sets nothing. The bit stays set after the pin returns high.
- R3: Internal line i (`int_req[i]`) that is high at a clock edge sets pending bit 9+i.
- R4: A pending source whose level is 0 never raises `irq`.
- R5: Among the pending sources with a nonzero level, excluding source 0, the highest level wins. When two sources share the highest level, the lower source number wins.
- R6: `irq` is high only when the level of the winner is strictly greater than the current service level.
- R7: A read of address 5 while `irq` is high returns bit 7 = 1 and the winner's number in bits 4:0. The same read clears that pending bit, pushes the old service level and makes the winner's level current. A read of address 5 while `irq` is low returns 0 and changes nothing.
- R8: A write to address 6 pops the service-level stack, so requests can nest up to 7 deep. On an empty stack the write leaves level 0. The status register holds the current level in bits 2:0 and the stack depth in bits 10:8.
- R9: The fast pin (`fiq_n`) follows the R2 timing and sets pending bit 0. `fiq` is high while bit 0 is pending and source 0 has a nonzero level. Source 0 never takes part in `irq`.
- R10: Writing address 4 clears each pending bit that has a 1 in the written data and leaves every other pending bit unchanged.
- R11: Addresses 0 to 3 hold the levels, with source s in word s/8 at bits 4*(s%8)+2 down to 4*(s%8). Fields that have no source behind them read 0, and so do all bits that are not level bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_n | input | 1 | Fast external request, active low |
| ext_req_n | input | 8 | General external requests, active low |
| int_req | input | 19 | Internal peripheral requests, active high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only address 5 has a side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Normal interrupt request to the CPU |
| fiq | output | 1 | Fast interrupt request to the CPU |

## Verification
A wrong arbitration result shows at once in the number returned by the next acknowledge. A wrong service level shows in the status register, and also as an `irq` that stays high or stays low when it should not, on the cycle after the acknowledge or end-of-service access. Stack corruption stays hidden until the pops, so the bench nests all seven levels and then checks every level that comes back. A wrong pin filter only shows as a pending bit that is missing or extra a few cycles after the pulse. For that reason the bench drives pulses that are one edge long and two edges long.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [2:0] {
    RA_LVL0 = 3'd0,
    RA_LVL1 = 3'd1,
    RA_LVL2 = 3'd2,
    RA_LVL3 = 3'd3,
    RA_PEND = 3'd4,
    RA_ACK  = 3'd5,
    RA_EOI  = 3'd6,
    RA_STAT = 3'd7
  } lic_addr_e;

  localparam int FIELD_W  = 4;
  localparam int PER_WORD = 8;
endpackage

// File: rtl/lic_ext_sync.sv
// Two-flop synchronizer plus low-for-two-edges falling detector per pin.
module lic_ext_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_n,
  output logic [W-1:0] hit
);
  for (genvar b = 0; b < W; b++) begin : g_pin
    logic meta_q, samp_q, hist_q, old_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        samp_q <= 1'b1;
        hist_q <= 1'b1;
        old_q  <= 1'b1;
      end else begin
        meta_q <= pin_n[b];
        samp_q <= meta_q;
        hist_q <= samp_q;
        old_q  <= hist_q;
      end
    end
    // low now, low one edge before, high the edge before that
    assign hit[b] = !samp_q && !hist_q && old_q;
  end
endmodule

// File: rtl/lic_arbiter.sv
// Highest nonzero level wins; equal levels resolve to the lowest number.
module lic_arbiter #(
  parameter int NUM_SRC = 28,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]       cand,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     win_valid,
  output logic [ID_W-1:0]          win_id,
  output logic [LVL_W-1:0]         win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (lvl_flat[i*LVL_W +: LVL_W] != '0) &&
          (lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_lvl   = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/lic_level_stack.sv
// Current service level with a push-down store of the interrupted levels.
module lic_level_stack #(
  parameter int LVL_W = 3,
  parameter int DEPTH = 7,
  parameter int DEP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [DEP_W-1:0] depth
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] cur_q, cur_d, top_val;
  logic [DEP_W-1:0] depth_q, depth_d;

  always_comb begin
    top_val = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (depth_q == DEP_W'(e + 1)) top_val = stk_q[e];
    end
  end

  always_comb begin
    cur_d   = cur_q;
    depth_d = depth_q;
    if (push) begin
      cur_d   = push_lvl;
      depth_d = depth_q + 1'b1;
    end else if (pop && depth_q != '0) begin
      cur_d   = top_val;
      depth_d = depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      depth_q <= '0;
    end else begin
      cur_q   <= cur_d;
      depth_q <= depth_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && depth_q == DEP_W'(e)) stk_q[e] <= cur_q;
    end
  end

  assign cur_lvl = cur_q;
  assign depth   = depth_q;
endmodule

// File: rtl/lic_top.sv
module lic_top
  import lic_pkg::*;
#(
  parameter int N_EXT = 8,
  parameter int N_INT = 19,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fiq_n,
  input  logic [N_EXT-1:0] ext_req_n,
  input  logic [N_INT-1:0] int_req,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             fiq
);
  localparam int NUM_SRC   = 1 + N_EXT + N_INT;
  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int STK_DEPTH = (1 << LVL_W) - 1;
  localparam int DEP_W     = $clog2(STK_DEPTH + 1);
  localparam int LVL_WORDS = (NUM_SRC + PER_WORD - 1) / PER_WORD;
  localparam int SLOTS     = LVL_WORDS * PER_WORD;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // external pins: bit 0 is the fast pin
  logic [N_EXT:0] ext_hit;
  lic_ext_sync #(.W(N_EXT + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_n ({ext_req_n, fiq_n}),
    .hit   (ext_hit)
  );

  logic                     ack, eoi;
  logic                     win_valid;
  logic [ID_W-1:0]          win_id;
  logic [LVL_W-1:0]         win_lvl;
  logic [LVL_W-1:0]         cur_lvl;
  logic [DEP_W-1:0]         stk_depth;
  logic [NUM_SRC*LVL_W-1:0] lvl_q, lvl_d;
  logic [SLOTS*FIELD_W-1:0] lvl_pad;
  logic [NUM_SRC-1:0]       pend_q, pend_d, pend_set, pend_clr, ack_mask;
  logic                     wdata_spare;

  assign eoi = bus_wr && (bus_addr == RA_EOI);
  assign ack = bus_rd && (bus_addr == RA_ACK) && irq;

  // level fields: per-source write enable, zero-padded readback image
  for (genvar s = 0; s < SLOTS; s++) begin : g_lvl
    if (s < NUM_SRC) begin : g_real
      logic wr_en;
      assign wr_en = bus_wr && (bus_addr == 3'(s / PER_WORD));
      assign lvl_d[s*LVL_W +: LVL_W] = wr_en ?
          bus_wdata[(s % PER_WORD)*FIELD_W +: LVL_W] : lvl_q[s*LVL_W +: LVL_W];
      assign lvl_pad[s*FIELD_W +: LVL_W] = lvl_q[s*LVL_W +: LVL_W];
      if (LVL_W < FIELD_W) begin : g_fill
        assign lvl_pad[s*FIELD_W+LVL_W +: FIELD_W-LVL_W] = '0;
      end
    end else begin : g_none
      assign lvl_pad[s*FIELD_W +: FIELD_W] = '0;
    end
  end

  // pending: set wins over clear so a fresh edge is never lost
  assign pend_set = {int_req, ext_hit};
  assign pend_clr = (bus_wr && bus_addr == RA_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign ack_mask = ack ? (NUM_SRC'(1) << win_id) : '0;
  assign pend_d   = (pend_q & ~pend_clr & ~ack_mask) | pend_set;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
    end
  end

  lic_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .cand      (pend_q & ~NUM_SRC'(1)),
    .lvl_flat  (lvl_q),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  lic_level_stack #(.LVL_W(LVL_W), .DEPTH(STK_DEPTH), .DEP_W(DEP_W)) u_stk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (ack),
    .pop      (eoi),
    .push_lvl (win_lvl),
    .cur_lvl  (cur_lvl),
    .depth    (stk_depth)
  );

  assign irq = win_valid && (win_lvl > cur_lvl);
  assign fiq = pend_q[0] && (lvl_q[LVL_W-1:0] != '0);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_PEND: bus_rdata[NUM_SRC-1:0] = pend_q;
      RA_ACK: begin
        bus_rdata[7] = irq;
        if (irq) bus_rdata[ID_W-1:0] = win_id;
      end
      RA_STAT: begin
        bus_rdata[LVL_W-1:0]  = cur_lvl;
        bus_rdata[8 +: DEP_W] = stk_depth;
      end
      default: begin
        for (int w = 0; w < LVL_WORDS; w++) begin
          if (bus_addr == 3'(w)) bus_rdata = lvl_pad[w*32 +: 32];
        end
      end
    endcase
  end

  assign wdata_spare = ^bus_wdata;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int NUM_SRC = 28,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 5,
  parameter int DEP_W   = 3,
  parameter int DEPTH   = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq,
  input logic                     ack,
  input logic                     eoi,
  input logic                     win_valid,
  input logic [ID_W-1:0]          win_id,
  input logic [LVL_W-1:0]         win_lvl,
  input logic [LVL_W-1:0]         cur_lvl,
  input logic [DEP_W-1:0]         stk_depth,
  input logic [NUM_SRC*LVL_W-1:0] lvl_q
);
  assert_winner_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> lvl_q[win_id*LVL_W +: LVL_W] != '0);

  assert_irq_headroom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cur_lvl != '1);

  assert_ack_takes_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cur_lvl == $past(win_lvl));

  assert_ack_pushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> stk_depth == DEP_W'($past(stk_depth) + 1'b1));

  assert_eoi_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && stk_depth != '0) |=> stk_depth == DEP_W'($past(stk_depth) - 1'b1));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stk_depth) <= DEPTH);
endmodule

bind lic_top lic_checker #(
  .NUM_SRC (NUM_SRC),
  .LVL_W   (LVL_W),
  .ID_W    (ID_W),
  .DEP_W   (DEP_W),
  .DEPTH   (STK_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq       (irq),
  .ack       (ack),
  .eoi       (eoi),
  .win_valid (win_valid),
  .win_id    (win_id),
  .win_lvl   (win_lvl),
  .cur_lvl   (cur_lvl),
  .stk_depth (stk_depth),
  .lvl_q     (lvl_q)
);

// File: tb/lic_top_tb.sv
module lic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fiq_n;
  logic [7:0]  ext_req_n;
  logic [18:0] int_req;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, fiq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  lic_top u_dut (
    .clk(clk), .rst_n(rst_n), .fiq_n(fiq_n), .ext_req_n(ext_req_n),
    .int_req(int_req), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .fiq(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic br(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_int(input int i);
    @(negedge clk);
    int_req[i] = 1'b1;
    @(negedge clk);
    int_req[i] = 1'b0;
  endtask

  task automatic low_ext(input int k, input int edges);
    @(negedge clk);
    ext_req_n[k] = 1'b0;
    repeat (edges) @(negedge clk);
    ext_req_n[k] = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic low_fiq(input int edges);
    @(negedge clk);
    fiq_n = 1'b0;
    repeat (edges) @(negedge clk);
    fiq_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    br(3'd4, d); chk("R1 pending", d, 0);
    br(3'd7, d); chk("R1 status", d, 0);
    for (int w = 0; w < 4; w++) begin
      br(3'(w), d); chk("R1 level word", d, 0);
    end
  endtask

  task automatic t_layout;
    logic [31:0] d;
    bw(3'd1, 32'h7654_3210);
    br(3'd1, d); chk("R11 word1 readback", d, 32'h7654_3210);
    bw(3'd3, 32'hFFFF_FFFF);
    br(3'd3, d); chk("R11 word3 unused fields", d, 32'h0000_7777);
    bw(3'd1, 0); bw(3'd3, 0);
  endtask

  task automatic t_internal;
    logic [31:0] d;
    pulse_int(2);
    br(3'd4, d); chk("R3 pending bit 11", d, 32'h800);
    chk("R4 level 0 no irq", 32'(irq), 0);
    pulse_int(7);
    bw(3'd4, 32'h800);
    br(3'd4, d); chk("R10 clear one keeps other", d, 32'h1 << 16);
    bw(3'd4, 32'h1 << 16);
    br(3'd4, d); chk("R10 all clear", d, 0);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    low_ext(5, 1);
    br(3'd4, d); chk("R2 one-edge pulse ignored", d, 0);
    low_ext(5, 2);
    br(3'd4, d); chk("R2 two-edge pulse sets bit 6", d, 32'h40);
    repeat (4) @(negedge clk);
    br(3'd4, d); chk("R2 bit held after release", d, 32'h40);
    bw(3'd4, 32'h40);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    bw(3'd0, 32'h0003_0000);   // src4 level 3
    bw(3'd1, 32'h0005_5000);   // src11, src12 level 5
    pulse_int(3);
    pulse_int(2);
    low_ext(3, 3);
    br(3'd4, d); chk("R2 R3 pending set", d, 32'h1810);
    chk("R6 irq above level 0", 32'(irq), 1);
    br(3'd5, d); chk("R5 tie goes to lowest number", d, 32'h8B);
    br(3'd7, d); chk("R7 level 5 depth 1", d, 32'h105);
    br(3'd4, d); chk("R7 acked bit cleared", d, 32'h1010);
    chk("R6 equal level blocked", 32'(irq), 0);
    bw(3'd6, 0);
    br(3'd7, d); chk("R8 pop to 0", d, 0);
    chk("R6 irq again", 32'(irq), 1);
    br(3'd5, d); chk("R5 second level-5 source", d, 32'h8C);
    bw(3'd6, 0);
    br(3'd5, d); chk("R5 lower level source", d, 32'h84);
    br(3'd7, d); chk("R7 level 3 depth 1", d, 32'h103);
    bw(3'd6, 0);
    br(3'd5, d); chk("R7 no request reads 0", d, 0);
    br(3'd7, d); chk("R7 idle read no push", d, 0);
    bw(3'd0, 0); bw(3'd1, 0);
  endtask

  task automatic t_nesting;
    logic [31:0] d;
    bw(3'd1, 32'h3210_0000);   // src13..15 levels 1..3
    bw(3'd2, 32'h0000_7654);   // src16..19 levels 4..7
    for (int j = 0; j < 7; j++) begin
      pulse_int(4 + j);
      br(3'd5, d); chk("R7 nested ack number", d, 32'h80 | 32'(13 + j));
      br(3'd7, d); chk("R8 nested status", d, (32'(j + 1) << 8) | 32'(j + 1));
    end
    bw(3'd2, 32'h0007_7654);   // src20 level 7
    pulse_int(11);
    chk("R6 level 7 blocked at level 7", 32'(irq), 0);
    br(3'd5, d); chk("R7 blocked read reads 0", d, 0);
    for (int j = 6; j >= 0; j--) begin
      bw(3'd6, 0);
      br(3'd7, d); chk("R8 pop status", d, (32'(j) << 8) | 32'(j));
      if (j == 6) chk("R6 irq after first pop", 32'(irq), 1);
    end
    bw(3'd6, 0);
    br(3'd7, d); chk("R8 pop on empty", d, 0);
    bw(3'd4, 32'h1 << 20);
    br(3'd4, d); chk("R10 clear src20", d, 0);
    bw(3'd1, 0); bw(3'd2, 0);
  endtask

  task automatic t_fiq;
    logic [31:0] d;
    low_fiq(1);
    br(3'd4, d); chk("R9 one-edge fast pulse ignored", d, 0);
    low_fiq(3);
    br(3'd4, d); chk("R9 pending bit 0", d, 32'h1);
    chk("R9 level 0 no fiq", 32'(fiq), 0);
    bw(3'd0, 32'h2);
    chk("R9 fiq raised", 32'(fiq), 1);
    chk("R9 no irq from source 0", 32'(irq), 0);
    br(3'd5, d); chk("R9 not acked as irq", d, 0);
    bw(3'd4, 32'h1);
    chk("R9 fiq cleared", 32'(fiq), 0);
    bw(3'd0, 0);
  endtask

  initial begin
    rst_n = 1'b0; fiq_n = 1'b1; ext_req_n = '1; int_req = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    t_internal();
    t_ext();
    t_priority();
    t_nesting();
    t_fiq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (R1..): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule